// File: doc/BRIEF.md
# Operand Slot Pool

The block holds a shared set of slots for arithmetic operations that wait on one or two operands fetched from memory. A requester first claims a slot, and only then issues its operand fetches. This ordering means that flows running at the same time cannot each hold some slots while waiting for more, so they cannot deadlock. The slot records the flow tag and the operation code. Returning operand data is written into the slot by slot number and operand index. When the last operand that the operation needs has landed, the slot number joins a ready stream that feeds the arithmetic unit. After the arithmetic unit finishes with the slot, it hands the slot number back through the release port.

Free slot numbers and ready slot numbers each sit in a queue of their own, so the block never searches the slot array. The free queue is first-in first-out. After reset it holds every slot number in ascending order. An operation that needs only one operand has its second operand flagged as present when the slot is claimed.

Top module: `opnd_pool`

## Requirements
- R1: After reset the ready stream is empty (`rdy_valid` low) and `wr_err` is low. Successive claims receive slot numbers 0, 1, 2 and so on in ascending order.
- R2: A claim is granted (`alloc_gnt` high, combinationally) only while `alloc_req` is high and at least one slot is free, with `alloc_id` giving the granted slot. While no slot is free, `alloc_gnt` stays low and the requester must hold `alloc_req`. A slot released in some cycle can be granted from the next cycle on.
- R3: An operand write (`wr_sel` 0 selects the first operand, 1 the second) stores `wr_data` into the slot. The slot enters the ready queue on the clock edge that takes the write which completes it, so `rdy_valid` can rise in the cycle after that write.
- R4: A claim made with `alloc_single` high needs only the first operand. One write with `wr_sel` 0 makes the slot ready.
- R5: The ready stream presents slots in the order they became ready, carrying the slot number, flow tag, operation code and both operands. A slot leaves the stream on a cycle with `rdy_valid` and `rdy_ready` both high. While it waits, its outputs hold steady.
- R6: A release of a claimed slot puts its number at the tail of the free queue. Free numbers are handed out again in the order they were released.
- R7: A write to a slot that is not claimed, or to an operand that is already present, raises `wr_err` in the following cycle and changes no slot. It neither marks the slot ready nor alters stored data.
- R8: A release naming a slot that is not claimed is ignored, and the free queue order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request to claim a slot |
| alloc_single | input | 1 | Operation needs only the first operand |
| alloc_flow | input | FLOW_W | Flow tag stored with the slot |
| alloc_opc | input | OPC_W | Operation code stored with the slot |
| alloc_gnt | output | 1 | Claim granted this cycle |
| alloc_id | output | ID_W | Slot number granted |
| wr_en | input | 1 | Operand write strobe |
| wr_id | input | ID_W | Slot number written |
| wr_sel | input | 1 | Operand index, 0 first, 1 second |
| wr_data | input | DATA_W | Operand value |
| wr_err | output | 1 | Previous cycle's write was rejected |
| rdy_valid | output | 1 | A ready slot is presented |
| rdy_ready | input | 1 | Consumer takes the presented slot |
| rdy_id | output | ID_W | Presented slot number |
| rdy_flow | output | FLOW_W | Presented flow tag |
| rdy_opc | output | OPC_W | Presented operation code |
| rdy_a | output | DATA_W | Presented first operand |
| rdy_b | output | DATA_W | Presented second operand |
| rel_en | input | 1 | Release strobe |
| rel_id | input | ID_W | Slot number released |

## Verification
The checks assume that a slot is released only after it has left the ready stream. They also assume that the consumer does not release a slot that is still queued as ready. Under these assumptions, the free count plus the number of claimed slots always equals the slot count. The bench keeps to this rule by releasing slots only after it has popped all of them. It sends bad writes and bad releases only to slots that are genuinely unclaimed or already complete, so the rejection paths are exercised without breaking the slot accounting.

// File: rtl/opnd_pool.sv
module opnd_pool #(
  parameter int SLOTS  = 128,
  parameter int FLOW_W = 8,
  parameter int OPC_W  = 4,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(SLOTS),
  localparam int CNT_W = ID_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              alloc_single,
  input  logic [FLOW_W-1:0] alloc_flow,
  input  logic [OPC_W-1:0]  alloc_opc,
  output logic              alloc_gnt,
  output logic [ID_W-1:0]   alloc_id,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  output logic              rdy_valid,
  input  logic              rdy_ready,
  output logic [ID_W-1:0]   rdy_id,
  output logic [FLOW_W-1:0] rdy_flow,
  output logic [OPC_W-1:0]  rdy_opc,
  output logic [DATA_W-1:0] rdy_a,
  output logic [DATA_W-1:0] rdy_b,
  input  logic              rel_en,
  input  logic [ID_W-1:0]   rel_id
);

  function automatic logic [ID_W-1:0] nxt(input logic [ID_W-1:0] p);
    return (p == ID_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [SLOTS-1:0]  used, have_a, have_b;
  logic [FLOW_W-1:0] s_flow [SLOTS];
  logic [OPC_W-1:0]  s_opc  [SLOTS];
  logic [DATA_W-1:0] s_a    [SLOTS];
  logic [DATA_W-1:0] s_b    [SLOTS];

  logic [ID_W-1:0]  fq [SLOTS];
  logic [ID_W-1:0]  fhead, ftail;
  logic [CNT_W-1:0] fcnt;

  logic [ID_W-1:0]  rq [SLOTS];
  logic [ID_W-1:0]  rhead, rtail;
  logic [CNT_W-1:0] rcnt;

  logic wr_ok, wr_done, rel_ok, pop;

  assign alloc_gnt = alloc_req && (fcnt != '0);
  assign alloc_id  = fq[fhead];
  assign wr_ok     = wr_en && used[wr_id] && !(wr_sel ? have_b[wr_id] : have_a[wr_id]);
  assign wr_done   = wr_ok && (wr_sel ? have_a[wr_id] : have_b[wr_id]);
  assign rel_ok    = rel_en && used[rel_id];
  assign rdy_valid = rcnt != '0;
  assign pop       = rdy_valid && rdy_ready;
  assign rdy_id    = rq[rhead];
  assign rdy_flow  = s_flow[rdy_id];
  assign rdy_opc   = s_opc[rdy_id];
  assign rdy_a     = s_a[rdy_id];
  assign rdy_b     = s_b[rdy_id];

  always_ff @(posedge clk) begin
    if (rst) begin
      used   <= '0;
      have_a <= '0;
      have_b <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        fq[i]     <= ID_W'(i);
        rq[i]     <= '0;
        s_flow[i] <= '0;
        s_opc[i]  <= '0;
        s_a[i]    <= '0;
        s_b[i]    <= '0;
      end
      fhead  <= '0;
      ftail  <= '0;
      fcnt   <= CNT_W'(SLOTS);
      rhead  <= '0;
      rtail  <= '0;
      rcnt   <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr_en && !wr_ok;
      if (alloc_gnt) begin
        used[alloc_id]   <= 1'b1;
        have_a[alloc_id] <= 1'b0;
        have_b[alloc_id] <= alloc_single;
        s_flow[alloc_id] <= alloc_flow;
        s_opc[alloc_id]  <= alloc_opc;
        fhead <= nxt(fhead);
      end
      if (rel_ok) begin
        used[rel_id] <= 1'b0;
        fq[ftail]    <= rel_id;
        ftail        <= nxt(ftail);
      end
      if (alloc_gnt && !rel_ok)      fcnt <= fcnt - 1'b1;
      else if (rel_ok && !alloc_gnt) fcnt <= fcnt + 1'b1;
      if (wr_ok) begin
        if (wr_sel) begin
          have_b[wr_id] <= 1'b1;
          s_b[wr_id]    <= wr_data;
        end else begin
          have_a[wr_id] <= 1'b1;
          s_a[wr_id]    <= wr_data;
        end
      end
      if (wr_done) begin
        rq[rtail] <= wr_id;
        rtail     <= nxt(rtail);
      end
      if (pop) rhead <= nxt(rhead);
      if (wr_done && !pop)      rcnt <= rcnt + 1'b1;
      else if (pop && !wr_done) rcnt <= rcnt - 1'b1;
    end
  end

endmodule

// File: rtl/opnd_pool_chk.sv
module opnd_pool_chk #(
  parameter int SLOTS = 128,
  parameter int ID_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_req,
  input logic             alloc_gnt,
  input logic [ID_W-1:0]  alloc_id,
  input logic             wr_en,
  input logic             wr_err,
  input logic             rdy_valid,
  input logic             rdy_ready,
  input logic [ID_W-1:0]  rdy_id,
  input logic [SLOTS-1:0] used,
  input logic [ID_W:0]    fcnt
);

  a_r2_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> alloc_req);

  a_r2_stall_when_empty: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && fcnt == '0) |-> !alloc_gnt);

  a_r2_grant_free_slot: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> !used[alloc_id]);

  a_r6_slot_conservation: assert property (@(posedge clk) disable iff (rst)
    (32'(fcnt) + 32'($countones(used))) == SLOTS);

  a_r5_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (rdy_valid && !rdy_ready) |=> (rdy_valid && $stable(rdy_id)));

  a_r7_err_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));

endmodule

bind opnd_pool opnd_pool_chk #(.SLOTS(SLOTS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
  .alloc_id(alloc_id), .wr_en(wr_en), .wr_err(wr_err),
  .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_id(rdy_id),
  .used(used), .fcnt(fcnt)
);

// File: tb/sim_opnd_pool.sv
module sim_opnd_pool;
  localparam int N = 8, FW = 4, OW = 3, DW = 16, IW = 3;

  logic clk = 0, rst = 1;
  logic alloc_req = 0, alloc_single = 0;
  logic [FW-1:0] alloc_flow = '0;
  logic [OW-1:0] alloc_opc = '0;
  logic alloc_gnt;
  logic [IW-1:0] alloc_id;
  logic wr_en = 0, wr_sel = 0;
  logic [IW-1:0] wr_id = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_err, rdy_valid, rdy_ready = 0;
  logic [IW-1:0] rdy_id;
  logic [FW-1:0] rdy_flow;
  logic [OW-1:0] rdy_opc;
  logic [DW-1:0] rdy_a, rdy_b;
  logic rel_en = 0;
  logic [IW-1:0] rel_id = '0;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  opnd_pool #(.SLOTS(N), .FLOW_W(FW), .OPC_W(OW), .DATA_W(DW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic single_of(input int i);
    return (i == 3 || i == 6);
  endfunction

  function automatic int perm(input int k);
    return (k * 3) % N;
  endfunction

  task automatic wr(input int id, input int sel, input int d);
    wr_en = 1; wr_id = IW'(id); wr_sel = sel[0]; wr_data = DW'(d);
    cyc();
    wr_en = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    cyc();
    chk("R1 ready empty", rdy_valid, 0);
    chk("R1 err low", wr_err, 0);

    wr(0, 0, 16'hdead);
    chk("R7 unclaimed write err", wr_err, 1);
    chk("R7 unclaimed not ready", rdy_valid, 0);
    rel_en = 1; rel_id = 5; cyc(); rel_en = 0;

    for (int i = 0; i < N; i++) begin
      alloc_req = 1; alloc_single = single_of(i);
      alloc_flow = FW'(i + 5); alloc_opc = OW'(7 - i);
      #1;
      chk("R2 grant", alloc_gnt, 1);
      chk("R1 R8 ascending id", alloc_id, i);
      cyc();
    end
    #1;
    chk("R2 stall when full", alloc_gnt, 0);
    alloc_req = 0;

    for (int i = 0; i < N; i++)
      if (!single_of(i)) wr(i, 1, 16'h2000 + i * 7);
    chk("R3 not ready on partial", rdy_valid, 0);
    wr(1, 1, 16'hbeef);
    chk("R7 duplicate err", wr_err, 1);

    for (int k = 0; k < N; k++) begin
      wr(perm(k), 0, 16'h1000 + perm(k) * 3);
      if (k == 0) begin
        chk("R3 ready next cycle", rdy_valid, 1);
        chk("R4 R3 first ready id", rdy_id, perm(0));
      end
    end
    wr(perm(0), 0, 16'hffff);
    chk("R7 rewrite err", wr_err, 1);

    rdy_ready = 0;
    cyc();
    chk("R5 held", rdy_id, perm(0));
    rdy_ready = 1;
    for (int k = 0; k < N; k++) begin
      int id;
      id = perm(k);
      #1;
      chk("R5 valid", rdy_valid, 1);
      chk("R5 order", rdy_id, id);
      chk("R5 flow", rdy_flow, id + 5);
      chk("R5 opc", rdy_opc, 7 - id);
      chk("R5 R7 operand a", rdy_a, 16'h1000 + id * 3);
      if (!single_of(id)) chk("R5 R7 operand b", rdy_b, 16'h2000 + id * 7);
      cyc();
    end
    rdy_ready = 0;
    chk("R5 drained", rdy_valid, 0);

    alloc_req = 1; alloc_single = 1; alloc_flow = 1; alloc_opc = 1;
    rel_en = 1; rel_id = IW'(perm(0));
    #1;
    chk("R2 stall same cycle as release", alloc_gnt, 0);
    cyc();
    rel_en = 0;
    #1;
    chk("R2 grant after release", alloc_gnt, 1);
    chk("R6 released id reused", alloc_id, perm(0));
    cyc();
    alloc_req = 0;
    for (int k = 1; k < N; k++) begin
      rel_en = 1; rel_id = IW'(perm(k)); cyc();
    end
    rel_en = 0;
    alloc_single = 1;
    for (int k = 1; k < N; k++) begin
      alloc_req = 1;
      #1;
      chk("R6 release order", alloc_id, perm(k));
      cyc();
    end
    alloc_req = 0;

    wr(perm(0), 0, 16'h0abc);
    chk("R4 single ready", rdy_valid, 1);
    chk("R4 single id", rdy_id, perm(0));
    chk("R4 single data", rdy_a, 16'h0abc);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule